// File: doc/BRIEF.md
# Operate-Group Conditional Skip Unit

This block evaluates the skip and clear micro-operations of a 12-bit accumulator machine's operate instruction group. The decoder supplies the micro-op bits, the current accumulator, the link bit and the default next program counter. The block returns the new accumulator value, a next counter that may be advanced past one more word, a strobe that writes 1 into the halted control register, and read-enable, redirect and error flags.

There are two polarities. In the normal sense, any selected condition that holds causes a skip. In the reversed sense, the skip is taken by default, and any selected condition that holds cancels it. This makes each reversed test the complement of its normal partner. All outputs are computed combinationally and captured in one register stage.

Top module: `skip_unit`

## Requirements
- R1: With reverse_i=0, the skip is taken if any of these holds: neg_tst_i=1 and acc_i[11]=1, zero_tst_i=1 and acc_i=0, link_tst_i=1 and link_i=1.
- R2: With reverse_i=1, the skip is taken unless one of these holds: neg_tst_i=1 and acc_i[11]=1, zero_tst_i=1 and acc_i=0, link_tst_i=1 and link_i=1. This tests for a positive accumulator (zero counts as positive), a nonzero accumulator, and a clear link.
- R3: When the skip is taken, next_pc_o[11:0] is next_pc_i[11:0]+1 modulo 4096, and next_pc_o[14:12] equals next_pc_i[14:12].
- R4: When the skip is not taken, next_pc_o equals next_pc_i.
- R5: With cla_i=1, acc_o is 0, and the tests still see the old acc_i. With cla_i=0, acc_o equals acc_i.
- R6: With halt_i=1, halt_set_o is 1 and ctl_wdata_o is 1. With halt_i=0, both are 0.
- R7: acc_rd_o is 1 exactly when neg_tst_i or zero_tst_i is set. link_rd_o equals link_tst_i. redirect_o is 1 for every valid operation.
- R8: err_o is 1 when osr_i is set on a valid operation.
- R9: With no test bits selected, the normal sense never skips and the reversed sense always skips.
- R10: All results appear one clock after a valid input. While valid_i=0, valid_o, halt_set_o, err_o, redirect_o, acc_rd_o and link_rd_o are 0. During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present |
| cla_i | input | 1 | Clear accumulator |
| neg_tst_i | input | 1 | Minus/plus test select |
| zero_tst_i | input | 1 | Zero/nonzero test select |
| link_tst_i | input | 1 | Link test select |
| reverse_i | input | 1 | Reversed sense |
| halt_i | input | 1 | Halt micro-op |
| osr_i | input | 1 | Switch-register option (unsupported) |
| acc_i | input | 12 | Accumulator |
| link_i | input | 1 | Link bit |
| next_pc_i | input | 15 | Default next counter |
| valid_o | output | 1 | Result valid |
| acc_o | output | 12 | New accumulator |
| next_pc_o | output | 15 | Updated next counter |
| halt_set_o | output | 1 | Write strobe for the halted control register |
| ctl_wdata_o | output | 12 | Control register write value |
| acc_rd_o | output | 1 | Accumulator was read |
| link_rd_o | output | 1 | Link was read |
| redirect_o | output | 1 | Counter may have been redirected |
| err_o | output | 1 | Unsupported option flagged |

## Verification
Every result is due exactly one rising edge after the stimulus that produced it, because one register stage sits between the inputs and the outputs. The bench applies inputs on the falling edge, waits for the next rising edge, and samples 1 ns later. This means each check reads the result of precisely one operation. The checks on idle inputs and on reset use the same timing, so a strobe that leaks into a later cycle is seen.

// File: rtl/skip_pkg.sv
package skip_pkg;
  typedef struct packed {
    logic cla;
    logic neg_tst;
    logic zero_tst;
    logic link_tst;
    logic rev;
    logic halt;
    logic osr;
  } uop_t;

  typedef struct packed {
    logic valid;
    logic halt_set;
    logic acc_rd;
    logic link_rd;
    logic redirect;
    logic err;
  } flag_t;
endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval #(
  parameter int DATA_W = 12
) (
  input  logic              neg_tst_i,
  input  logic              zero_tst_i,
  input  logic              link_tst_i,
  input  logic              rev_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  output logic              skip_o,
  output logic              acc_rd_o,
  output logic              link_rd_o
);
  localparam int MSB = DATA_W - 1;

  logic is_neg, is_zero, hit;

  assign is_neg  = acc_i[MSB];
  assign is_zero = ~|acc_i;
  // reversed sense shares the hit term: any hit cancels the default skip
  assign hit     = (neg_tst_i & is_neg) | (zero_tst_i & is_zero) | (link_tst_i & link_i);
  assign skip_o  = hit ^ rev_i;

  assign acc_rd_o  = neg_tst_i | zero_tst_i;
  assign link_rd_o = link_tst_i;
endmodule

// File: rtl/skip_pc_step.sv
module skip_pc_step #(
  parameter int DATA_W = 12,
  parameter int PC_W   = 15
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            skip_i,
  output logic [PC_W-1:0] pc_o
);
  logic [DATA_W-1:0] low_nxt;

  assign low_nxt = pc_i[DATA_W-1:0] + DATA_W'(skip_i);

  generate
    if (PC_W > DATA_W) begin : g_field
      assign pc_o = {pc_i[PC_W-1:DATA_W], low_nxt};
    end else begin : g_flat
      assign pc_o = low_nxt;
    end
  endgenerate
endmodule

// File: rtl/skip_out_stage.sv
module skip_out_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/skip_unit.sv
module skip_unit
  import skip_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PC_W   = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              cla_i,
  input  logic              neg_tst_i,
  input  logic              zero_tst_i,
  input  logic              link_tst_i,
  input  logic              reverse_i,
  input  logic              halt_i,
  input  logic              osr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  input  logic [PC_W-1:0]   next_pc_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              halt_set_o,
  output logic [DATA_W-1:0] ctl_wdata_o,
  output logic              acc_rd_o,
  output logic              link_rd_o,
  output logic              redirect_o,
  output logic              err_o
);
  localparam int FLAG_W = $bits(flag_t);
  localparam int REG_W  = FLAG_W + DATA_W + PC_W + DATA_W;

  uop_t              uop;
  flag_t             flg_d, flg_q;
  logic              skip, acc_rd, link_rd;
  logic [PC_W-1:0]   pc_nxt;
  logic [DATA_W-1:0] acc_nxt, ctl_nxt;
  logic [REG_W-1:0]  stage_d, stage_q;

  assign uop = '{cla: cla_i, neg_tst: neg_tst_i, zero_tst: zero_tst_i,
                 link_tst: link_tst_i, rev: reverse_i, halt: halt_i, osr: osr_i};

  skip_cond_eval #(.DATA_W(DATA_W)) i_cond (
    .neg_tst_i (uop.neg_tst),
    .zero_tst_i(uop.zero_tst),
    .link_tst_i(uop.link_tst),
    .rev_i     (uop.rev),
    .acc_i     (acc_i),
    .link_i    (link_i),
    .skip_o    (skip),
    .acc_rd_o  (acc_rd),
    .link_rd_o (link_rd)
  );

  skip_pc_step #(.DATA_W(DATA_W), .PC_W(PC_W)) i_pc (
    .pc_i  (next_pc_i),
    .skip_i(skip),
    .pc_o  (pc_nxt)
  );

  // clear happens after the tests sampled acc_i
  assign acc_nxt = uop.cla ? '0 : acc_i;
  assign ctl_nxt = uop.halt ? DATA_W'(1) : '0;

  always_comb begin
    flg_d.valid    = valid_i;
    flg_d.halt_set = valid_i & uop.halt;
    flg_d.acc_rd   = valid_i & acc_rd;
    flg_d.link_rd  = valid_i & link_rd;
    flg_d.redirect = valid_i;
    flg_d.err      = valid_i & uop.osr;
  end

  assign stage_d = {flg_d, acc_nxt, pc_nxt, ctl_nxt};

  skip_out_stage #(.W(REG_W)) i_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stage_d),
    .q_o   (stage_q)
  );

  assign {flg_q, acc_o, next_pc_o, ctl_wdata_o} = stage_q;
  assign valid_o    = flg_q.valid;
  assign halt_set_o = flg_q.halt_set;
  assign acc_rd_o   = flg_q.acc_rd;
  assign link_rd_o  = flg_q.link_rd;
  assign redirect_o = flg_q.redirect;
  assign err_o      = flg_q.err;
endmodule

// File: rtl/skip_unit_chk.sv
module skip_unit_chk #(
  parameter int DATA_W = 12,
  parameter int PC_W   = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              cla_i,
  input logic              neg_tst_i,
  input logic              zero_tst_i,
  input logic              link_tst_i,
  input logic              reverse_i,
  input logic              halt_i,
  input logic              osr_i,
  input logic [PC_W-1:0]   next_pc_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              halt_set_o,
  input logic [DATA_W-1:0] ctl_wdata_o,
  input logic              redirect_o,
  input logic              err_o
);
  logic no_tst;
  assign no_tst = !neg_tst_i && !zero_tst_i && !link_tst_i;

  AST_FIELD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> next_pc_o[PC_W-1:DATA_W] == $past(next_pc_i[PC_W-1:DATA_W])); // R3
  AST_NORMAL_NO_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !reverse_i && no_tst) |=> next_pc_o == $past(next_pc_i)); // R9
  AST_REVERSE_NO_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && reverse_i && no_tst) |=>
      next_pc_o[DATA_W-1:0] == DATA_W'($past(next_pc_i[DATA_W-1:0]) + 1'b1)); // R9
  AST_CLEAR_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cla_i) |=> acc_o == '0); // R5
  AST_HALT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && halt_i) |=> (halt_set_o && ctl_wdata_o == DATA_W'(1))); // R6
  AST_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (redirect_o && valid_o)); // R7
  AST_OSR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && osr_i) |=> err_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !halt_set_o && !err_o && !redirect_o)); // R10
endmodule

bind skip_unit skip_unit_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) i_skip_unit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .cla_i      (cla_i),
  .neg_tst_i  (neg_tst_i),
  .zero_tst_i (zero_tst_i),
  .link_tst_i (link_tst_i),
  .reverse_i  (reverse_i),
  .halt_i     (halt_i),
  .osr_i      (osr_i),
  .next_pc_i  (next_pc_i),
  .valid_o    (valid_o),
  .acc_o      (acc_o),
  .next_pc_o  (next_pc_o),
  .halt_set_o (halt_set_o),
  .ctl_wdata_o(ctl_wdata_o),
  .redirect_o (redirect_o),
  .err_o      (err_o)
);

// File: tb/test_skip_unit.sv
module test_skip_unit;
  typedef struct packed {
    logic        rev;
    logic        neg;
    logic        zer;
    logic        lnk;
    logic        cla;
    logic [11:0] acc;
    logic        link;
    logic [14:0] pc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'o4000, 1'b0, 15'o10100},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'o3777, 1'b0, 15'o10100},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'o0000, 1'b0, 15'o20200},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'o0001, 1'b1, 15'o20200},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'o1234, 1'b1, 15'o00300},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'o1234, 1'b0, 15'o00300},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'o0000, 1'b1, 15'o00400},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'o0005, 1'b0, 15'o70007},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'o0000, 1'b0, 15'o30010},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'o7777, 1'b0, 15'o30010},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 12'o0000, 1'b0, 15'o40020},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'o0017, 1'b1, 15'o50030},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'o6543, 1'b1, 15'o60040},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'o0100, 1'b0, 15'o00050}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, cla_i = 1'b0, neg_tst_i = 1'b0, zero_tst_i = 1'b0;
  logic        link_tst_i = 1'b0, reverse_i = 1'b0, halt_i = 1'b0, osr_i = 1'b0;
  logic [11:0] acc_i = '0;
  logic        link_i = 1'b0;
  logic [14:0] next_pc_i = '0;
  logic        valid_o, halt_set_o, acc_rd_o, link_rd_o, redirect_o, err_o;
  logic [11:0] acc_o, ctl_wdata_o;
  logic [14:0] next_pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  skip_unit i_skip_unit (
    .clk_i, .rst_ni, .valid_i, .cla_i, .neg_tst_i, .zero_tst_i, .link_tst_i,
    .reverse_i, .halt_i, .osr_i, .acc_i, .link_i, .next_pc_i,
    .valid_o, .acc_o, .next_pc_o, .halt_set_o, .ctl_wdata_o,
    .acc_rd_o, .link_rd_o, .redirect_o, .err_o
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic model_skip(input vec_t v);
    logic s;
    if (!v.rev) begin
      s = 1'b0;
      if (v.neg && v.acc[11])      s = 1'b1;
      if (v.zer && v.acc == 12'd0) s = 1'b1;
      if (v.lnk && v.link)         s = 1'b1;
    end else begin
      s = 1'b1;
      if (v.neg && v.acc[11])      s = 1'b0;
      if (v.zer && v.acc == 12'd0) s = 1'b0;
      if (v.lnk && v.link)         s = 1'b0;
    end
    return s;
  endfunction

  function automatic logic [14:0] model_pc(input vec_t v);
    if (model_skip(v)) return {v.pc[14:12], 12'(v.pc[11:0] + 12'd1)};
    return v.pc;
  endfunction

  task automatic apply(input vec_t v, input logic vld, input logic hlt, input logic osr);
    @(negedge clk_i);
    valid_i = vld; reverse_i = v.rev; neg_tst_i = v.neg; zero_tst_i = v.zer;
    link_tst_i = v.lnk; cla_i = v.cla; acc_i = v.acc; link_i = v.link;
    next_pc_i = v.pc; halt_i = hlt; osr_i = osr;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vec_t v;
    // R10 reset state
    #7;
    check("R10 reset valid", 32'(valid_o), 0);
    check("R10 reset pc", 32'(next_pc_o), 0);
    check("R10 reset flags", 32'({halt_set_o, acc_rd_o, link_rd_o, redirect_o, err_o}), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], 1'b1, 1'b0, 1'b0);
      check(VECS[i].rev ? "R2 skip pc" : "R1 skip pc", 32'(next_pc_o), 32'(model_pc(VECS[i])));
      check("R5 acc", 32'(acc_o), VECS[i].cla ? 0 : 32'(VECS[i].acc));
      check("R7 redirect", 32'(redirect_o), 1);
    end

    // R3 wrap inside low 12 bits, field kept
    v = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'o0, 1'b0, 15'o37777};
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R3 wrap", 32'(next_pc_o), 32'(15'o30000));
    // R9 reversed, no tests
    check("R9 reversed always skips", 32'(next_pc_o[11:0]), 0);
    // R4 / R9 normal, no tests
    v = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'o0, 1'b1, 15'o45555};
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R4 no skip pc", 32'(next_pc_o), 32'(15'o45555));
    check("R9 normal never skips", 32'(next_pc_o), 32'(15'o45555));

    // R5 test sees old acc despite clear
    v = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 12'o7000, 1'b0, 15'o00100};
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R5 old acc tested", 32'(next_pc_o), 32'(15'o00101));
    check("R5 cleared", 32'(acc_o), 0);

    // R6 halt
    v = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'o1, 1'b0, 15'o00200};
    apply(v, 1'b1, 1'b1, 1'b0);
    check("R6 halt strobe", 32'(halt_set_o), 1);
    check("R6 halt data", 32'(ctl_wdata_o), 1);
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R6 no halt", 32'({halt_set_o, ctl_wdata_o}), 0);

    // R7 read enables
    v = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'o1, 1'b0, 15'o0};
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R7 acc read neg", 32'({acc_rd_o, link_rd_o}), 32'b10);
    v = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 12'o1, 1'b0, 15'o0};
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R7 acc read zero", 32'({acc_rd_o, link_rd_o}), 32'b10);
    v = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'o1, 1'b0, 15'o0};
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R7 link read", 32'({acc_rd_o, link_rd_o}), 32'b01);
    v = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'o1, 1'b0, 15'o0};
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R7 no reads", 32'({acc_rd_o, link_rd_o}), 0);

    // R8 unsupported option
    apply(v, 1'b1, 1'b0, 1'b1);
    check("R8 osr err", 32'(err_o), 1);
    apply(v, 1'b1, 1'b0, 1'b0);
    check("R8 no err", 32'(err_o), 0);

    // R10 idle cycle with all micro-ops set
    v = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'o0, 1'b1, 15'o0};
    apply(v, 1'b0, 1'b1, 1'b1);
    check("R10 idle quiet",
          32'({valid_o, halt_set_o, acc_rd_o, link_rd_o, redirect_o, err_o}), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule